// File: doc/BRIEF.md
# Scaling Mode Configuration Controller

This block chooses how a video pipeline fits its incoming picture onto the outgoing raster. It holds one of three scaling modes: passthrough, upscale and downscale. From that mode and the input and output resolutions it works out the settings for the pipeline stages. These settings are the size of the window cut from the input, the target size of the downscaler placed before the frame store, and the target size of the upscaler placed after it. It also gives the size of the black background canvas and whether a black border surrounds the picture.

A debounced button pulse steps the mode to the next one in a fixed rotation. A hot-plug or format-change event resets the mode to a default chosen from the two resolutions. Whenever the mode or any resolution changes, the block recomputes every setting. It drives the new values on registered outputs and marks them with a single-cycle strobe. The settings hold steady between strobes, so downstream stages can latch them whenever they like.

Top module: `scale_mode_ctrl`

## Requirements
- R1: While reset is high, and after it until the first change, every size output is zero, all three flags are low and `cfg_valid` is low. The mode starts as passthrough.
- R2: Each `btn_pulse` without `hotplug` steps the mode: passthrough to upscale, upscale to downscale, downscale to passthrough.
- R3: `hotplug` sets the mode to downscale when the input is larger than the output, and to passthrough otherwise. It takes priority over `btn_pulse` in the same cycle. A hotplug that changes neither the mode nor any resolution produces no `cfg_valid` strobe.
- R4: The input counts as larger when its width or its height exceeds the output. It counts as equal when both dimensions match, and as smaller in every other case.
- R5: The two-thirds size of a dimension x is floor(2x/3), cleared in its two low bits to a multiple of 4. For example, 1280 gives 852 and 1000 gives 664.
- R6: In passthrough with the input larger, the clip window is the output size. Both scalers are off and there is no border.
- R7: In passthrough with the input equal or smaller, the clip window is the input size and both scalers are off. The border flag is set only when the input is smaller.
- R8: In upscale with the input larger or equal, the clip window is two-thirds of the output size. The upscaler is on, targets the output size, and there is no border.
- R9: In upscale with the input smaller, the clip window is the input size and the upscaler is on, targeting the output size.
- R10: In downscale with the input smaller, the clip window is the input size and the downscaler is on. It targets two-thirds of the input size and the border flag is set.
- R11: In downscale with the input larger or equal, the clip window is the input size. The downscaler is on, targets the output size, and there is no border.
- R12: A change seen at a clock edge appears on the outputs one edge later, with `cfg_valid` high for that one cycle. Outputs do not change in any cycle in which `cfg_valid` is low.
- R13: The background size is always the output size, and at most one scaler is on. A scaler that is off reports the size it receives as its target: the downscaler reports the clip size, and the upscaler reports the downscaler's target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_w | input | DIM_W | Input picture width |
| in_h | input | DIM_W | Input picture height |
| out_w | input | DIM_W | Output raster width |
| out_h | input | DIM_W | Output raster height |
| btn_pulse | input | 1 | One-cycle pulse that advances the mode |
| hotplug | input | 1 | One-cycle pulse on hot-plug or format change |
| clip_w | output | DIM_W | Clip window width |
| clip_h | output | DIM_W | Clip window height |
| dsc_w | output | DIM_W | Downscaler target width |
| dsc_h | output | DIM_W | Downscaler target height |
| usc_w | output | DIM_W | Upscaler target width |
| usc_h | output | DIM_W | Upscaler target height |
| bg_w | output | DIM_W | Background canvas width |
| bg_h | output | DIM_W | Background canvas height |
| border_en | output | 1 | Black border padding active |
| dsc_en | output | 1 | Downscaler active |
| usc_en | output | 1 | Upscaler active |
| cfg_valid | output | 1 | One-cycle strobe after each recomputation |

## Verification
The hardest case to reach is a hot-plug pulse that arrives together with a button pulse. The outcome has to follow the hot-plug default and not the rotation. The stimulus sets this up from passthrough with a smaller input, where the rotation would give upscale but the hot-plug must give passthrough. A second hard case is a hot-plug that changes nothing, which must stay silent. The bench counts strobes across that event to confirm none appears. Mixed resolutions, where one dimension is larger and the other smaller, check the either-dimension rule. Widths that are not multiples of three check the rounding down to a multiple of 4.

// File: rtl/scm_pkg.sv
package scm_pkg;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_UP   = 2'd1,
    MODE_DOWN = 2'd2
  } scale_mode_e;

  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_EQ = 2'd1,
    REL_GT = 2'd2
  } res_rel_e;

  function automatic scale_mode_e rotate_mode(scale_mode_e m);
    case (m)
      MODE_PASS: return MODE_UP;
      MODE_UP:   return MODE_DOWN;
      default:   return MODE_PASS;
    endcase
  endfunction

endpackage

// File: rtl/scm_res_cmp.sv
module scm_res_cmp
  import scm_pkg::*;
#(
  parameter int unsigned DIM_W = 14,
  parameter int unsigned NDIM  = 2
) (
  input  logic [NDIM-1:0][DIM_W-1:0] src_dim,
  input  logic [NDIM-1:0][DIM_W-1:0] dst_dim,
  output res_rel_e                   rel
);
  logic [NDIM-1:0] dim_gt;
  logic [NDIM-1:0] dim_eq;

  for (genvar d = 0; d < NDIM; d++) begin : g_dim
    assign dim_gt[d] = src_dim[d] > dst_dim[d];
    assign dim_eq[d] = src_dim[d] == dst_dim[d];
  end

  always_comb begin
    if (|dim_gt)      rel = REL_GT;
    else if (&dim_eq) rel = REL_EQ;
    else              rel = REL_LT;
  end
endmodule

// File: rtl/scm_two_thirds.sv
module scm_two_thirds #(
  parameter int unsigned DIM_W  = 14,
  parameter int unsigned ALIGN  = 4
) (
  input  logic [DIM_W-1:0] x,
  output logic [DIM_W-1:0] y
);
  localparam int unsigned ALW = $clog2(ALIGN);

  logic [DIM_W:0] dbl;
  logic [DIM_W:0] quo;

  assign dbl = {x, 1'b0};
  assign quo = dbl / (DIM_W+1)'(3);

  if (ALW > 0) begin : g_align
    assign y = {quo[DIM_W-1:ALW], {ALW{1'b0}}};
  end else begin : g_noalign
    assign y = quo[DIM_W-1:0];
  end
endmodule

// File: rtl/scm_mode_fsm.sv
module scm_mode_fsm
  import scm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        btn_pulse,
  input  logic        hotplug,
  input  res_rel_e    live_rel,
  output scale_mode_e mode_q,
  output logic        mode_chg
);
  scale_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (hotplug)        mode_d = (live_rel == REL_GT) ? MODE_DOWN : MODE_PASS;
    else if (btn_pulse) mode_d = rotate_mode(mode_q);
  end

  assign mode_chg = (mode_d != mode_q);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_PASS;
    else     mode_q <= mode_d;
  end

  // R2
  pass_to_up_chk: assert property (@(posedge clk) disable iff (rst)
    (btn_pulse && !hotplug && mode_q == MODE_PASS) |=> (mode_q == MODE_UP));
  // R2
  up_to_down_chk: assert property (@(posedge clk) disable iff (rst)
    (btn_pulse && !hotplug && mode_q == MODE_UP) |=> (mode_q == MODE_DOWN));
  // R2
  down_to_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (btn_pulse && !hotplug && mode_q == MODE_DOWN) |=> (mode_q == MODE_PASS));
  // R3
  hp_larger_chk: assert property (@(posedge clk) disable iff (rst)
    (hotplug && live_rel == REL_GT) |=> (mode_q == MODE_DOWN));
  // R3
  hp_fits_chk: assert property (@(posedge clk) disable iff (rst)
    (hotplug && live_rel != REL_GT) |=> (mode_q == MODE_PASS));
  // R2
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (logic'(mode_q == MODE_PASS) || mode_q == MODE_UP || mode_q == MODE_DOWN));
endmodule

// File: rtl/scm_cfg_table.sv
module scm_cfg_table
  import scm_pkg::*;
#(
  parameter int unsigned DIM_W = 14,
  parameter int unsigned NDIM  = 2
) (
  input  scale_mode_e                mode,
  input  res_rel_e                   rel,
  input  logic [NDIM-1:0][DIM_W-1:0] src_dim,
  input  logic [NDIM-1:0][DIM_W-1:0] dst_dim,
  input  logic [NDIM-1:0][DIM_W-1:0] src_23,
  input  logic [NDIM-1:0][DIM_W-1:0] dst_23,
  output logic [NDIM-1:0][DIM_W-1:0] clip_dim,
  output logic [NDIM-1:0][DIM_W-1:0] dsc_dim,
  output logic [NDIM-1:0][DIM_W-1:0] usc_dim,
  output logic                       border,
  output logic                       dsc_on,
  output logic                       usc_on
);
  always_comb begin
    clip_dim = src_dim;
    dsc_on   = 1'b0;
    usc_on   = 1'b0;
    border   = 1'b0;
    case (mode)
      MODE_UP: begin
        usc_on = 1'b1;
        if (rel != REL_LT) clip_dim = dst_23;
      end
      MODE_DOWN: begin
        dsc_on = 1'b1;
        border = (rel == REL_LT);
      end
      default: begin
        if (rel == REL_GT) clip_dim = dst_dim;
        border = (rel == REL_LT);
      end
    endcase
  end

  always_comb begin
    dsc_dim = clip_dim;
    if (dsc_on) dsc_dim = (rel == REL_LT) ? src_23 : dst_dim;
    usc_dim = usc_on ? dst_dim : dsc_dim;
  end
endmodule

// File: rtl/scale_mode_ctrl.sv
module scale_mode_ctrl
  import scm_pkg::*;
#(
  parameter int unsigned DIM_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIM_W-1:0] in_w,
  input  logic [DIM_W-1:0] in_h,
  input  logic [DIM_W-1:0] out_w,
  input  logic [DIM_W-1:0] out_h,
  input  logic             btn_pulse,
  input  logic             hotplug,
  output logic [DIM_W-1:0] clip_w,
  output logic [DIM_W-1:0] clip_h,
  output logic [DIM_W-1:0] dsc_w,
  output logic [DIM_W-1:0] dsc_h,
  output logic [DIM_W-1:0] usc_w,
  output logic [DIM_W-1:0] usc_h,
  output logic [DIM_W-1:0] bg_w,
  output logic [DIM_W-1:0] bg_h,
  output logic             border_en,
  output logic             dsc_en,
  output logic             usc_en,
  output logic             cfg_valid
);
  localparam int unsigned NDIM = 2;
  localparam int unsigned DW   = 0;
  localparam int unsigned DH   = 1;

  logic [NDIM-1:0][DIM_W-1:0] in_now, out_now, in_q, out_q;
  logic [NDIM-1:0][DIM_W-1:0] in_23, out_23;
  logic [NDIM-1:0][DIM_W-1:0] clip_d, dsc_d, usc_d;
  logic        border_d, dsc_on_d, usc_on_d;
  logic        mode_chg, upd_q;
  scale_mode_e mode_q;
  res_rel_e    live_rel, held_rel;

  assign in_now  = {in_h, in_w};
  assign out_now = {out_h, out_w};

  scm_res_cmp #(.DIM_W(DIM_W), .NDIM(NDIM)) u_cmp_live (
    .src_dim(in_now), .dst_dim(out_now), .rel(live_rel)
  );

  scm_res_cmp #(.DIM_W(DIM_W), .NDIM(NDIM)) u_cmp_held (
    .src_dim(in_q), .dst_dim(out_q), .rel(held_rel)
  );

  scm_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .btn_pulse(btn_pulse), .hotplug(hotplug),
    .live_rel(live_rel), .mode_q(mode_q), .mode_chg(mode_chg)
  );

  for (genvar d = 0; d < NDIM; d++) begin : g_thirds
    scm_two_thirds #(.DIM_W(DIM_W), .ALIGN(4)) u_in23 (
      .x(in_q[d]), .y(in_23[d])
    );
    scm_two_thirds #(.DIM_W(DIM_W), .ALIGN(4)) u_out23 (
      .x(out_q[d]), .y(out_23[d])
    );
  end

  scm_cfg_table #(.DIM_W(DIM_W), .NDIM(NDIM)) u_table (
    .mode(mode_q), .rel(held_rel),
    .src_dim(in_q), .dst_dim(out_q), .src_23(in_23), .dst_23(out_23),
    .clip_dim(clip_d), .dsc_dim(dsc_d), .usc_dim(usc_d),
    .border(border_d), .dsc_on(dsc_on_d), .usc_on(usc_on_d)
  );

  // capture stage: resolutions and change flag
  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      out_q <= '0;
      upd_q <= 1'b0;
    end else begin
      in_q  <= in_now;
      out_q <= out_now;
      upd_q <= mode_chg || (in_now != in_q) || (out_now != out_q);
    end
  end

  // output stage: registered settings
  always_ff @(posedge clk) begin
    if (rst) begin
      clip_w <= '0; clip_h <= '0;
      dsc_w  <= '0; dsc_h  <= '0;
      usc_w  <= '0; usc_h  <= '0;
      bg_w   <= '0; bg_h   <= '0;
      border_en <= 1'b0;
      dsc_en    <= 1'b0;
      usc_en    <= 1'b0;
      cfg_valid <= 1'b0;
    end else begin
      cfg_valid <= upd_q;
      if (upd_q) begin
        clip_w <= clip_d[DW]; clip_h <= clip_d[DH];
        dsc_w  <= dsc_d[DW];  dsc_h  <= dsc_d[DH];
        usc_w  <= usc_d[DW];  usc_h  <= usc_d[DH];
        bg_w   <= out_q[DW];  bg_h   <= out_q[DH];
        border_en <= border_d;
        dsc_en    <= dsc_on_d;
        usc_en    <= usc_on_d;
      end
    end
  end

  // R12
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_valid |-> ($stable(clip_w) && $stable(clip_h) && $stable(dsc_w) &&
                    $stable(dsc_h) && $stable(usc_w) && $stable(usc_h) &&
                    $stable(bg_w) && $stable(bg_h) && $stable(border_en) &&
                    $stable(dsc_en) && $stable(usc_en)));
  // R13
  one_scaler_chk: assert property (@(posedge clk) disable iff (rst)
    !(dsc_en && usc_en));
  // R8
  up_fills_canvas_chk: assert property (@(posedge clk) disable iff (rst)
    usc_en |-> (usc_w == bg_w && usc_h == bg_h && !border_en));
  // R7
  border_fits_chk: assert property (@(posedge clk) disable iff (rst)
    border_en |-> (usc_w <= bg_w && usc_h <= bg_h && !usc_en));
  // R11
  down_fills_canvas_chk: assert property (@(posedge clk) disable iff (rst)
    (dsc_en && !border_en) |-> (dsc_w == bg_w && dsc_h == bg_h));
endmodule

// File: tb/scale_mode_ctrl_test.sv
module scale_mode_ctrl_test;
  localparam int DW = 14;
  localparam int VW = 8*DW + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] in_w = '0, in_h = '0, out_w = '0, out_h = '0;
  logic btn_pulse = 1'b0, hotplug = 1'b0;
  logic [DW-1:0] clip_w, clip_h, dsc_w, dsc_h, usc_w, usc_h, bg_w, bg_h;
  logic border_en, dsc_en, usc_en, cfg_valid;

  always #10 clk = ~clk;

  scale_mode_ctrl #(.DIM_W(DW)) uut (
    .clk(clk), .rst(rst), .in_w(in_w), .in_h(in_h), .out_w(out_w), .out_h(out_h),
    .btn_pulse(btn_pulse), .hotplug(hotplug),
    .clip_w(clip_w), .clip_h(clip_h), .dsc_w(dsc_w), .dsc_h(dsc_h),
    .usc_w(usc_w), .usc_h(usc_h), .bg_w(bg_w), .bg_h(bg_h),
    .border_en(border_en), .dsc_en(dsc_en), .usc_en(usc_en), .cfg_valid(cfg_valid)
  );

  wire [VW-1:0] act = {clip_w, clip_h, dsc_w, dsc_h, usc_w, usc_h, bg_w, bg_h,
                       border_en, dsc_en, usc_en};

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  logic [VW-1:0] exp_q[$];
  string         tag_q[$];
  logic [VW-1:0] last_exp = '0;

  // reference state: 0 passthrough, 1 upscale, 2 downscale
  int m_mode = 0;
  int m_iw = 0, m_ih = 0, m_ow = 0, m_oh = 0;

  function automatic int tw(int x);
    return ((2*x)/3) & ~3;
  endfunction

  function automatic int rel_of(int iw, int ih, int ow, int oh);
    if (iw > ow || ih > oh) return 2;
    if (iw == ow && ih == oh) return 1;
    return 0;
  endfunction

  function automatic logic [VW-1:0] model(int md, int iw, int ih, int ow, int oh);
    int r, cw, ch, dw_, dh_, uw, uh;
    logic bd, de, ue;
    r = rel_of(iw, ih, ow, oh);
    cw = iw; ch = ih; bd = 1'b0; de = 1'b0; ue = 1'b0;
    if (md == 0) begin
      if (r == 2) begin cw = ow; ch = oh; end
      bd = (r == 0);
      dw_ = cw; dh_ = ch; uw = cw; uh = ch;
    end else if (md == 1) begin
      ue = 1'b1;
      if (r != 0) begin cw = tw(ow); ch = tw(oh); end
      dw_ = cw; dh_ = ch; uw = ow; uh = oh;
    end else begin
      de = 1'b1;
      if (r == 0) begin dw_ = tw(iw); dh_ = tw(ih); bd = 1'b1; end
      else begin dw_ = ow; dh_ = oh; end
      uw = dw_; uh = dh_;
    end
    return {DW'(cw), DW'(ch), DW'(dw_), DW'(dh_), DW'(uw), DW'(uh),
            DW'(ow), DW'(oh), bd, de, ue};
  endfunction

  task automatic check(bit ok, string tag, logic [VW-1:0] a, logic [VW-1:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, a, e);
    end
  endtask

  // monitor: pops one expected record per strobe
  always @(negedge clk) begin
    if (!rst && cfg_valid) begin
      pulses++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected strobe", act, last_exp);
      end else begin
        logic [VW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_exp = e;
        check(act === e, t, act, e);
      end
    end
  end

  // driver: applies one stimulus and pushes the expected result
  task automatic step(int iw, int ih, int ow, int oh, bit btn, bit hp, string tag);
    int nm;
    bit changed;
    @(negedge clk);
    in_w = DW'(iw); in_h = DW'(ih); out_w = DW'(ow); out_h = DW'(oh);
    btn_pulse = btn; hotplug = hp;
    nm = m_mode;
    if (hp)       nm = (rel_of(iw, ih, ow, oh) == 2) ? 2 : 0;
    else if (btn) nm = (m_mode + 1) % 3;
    changed = (nm != m_mode) || iw != m_iw || ih != m_ih || ow != m_ow || oh != m_oh;
    m_mode = nm; m_iw = iw; m_ih = ih; m_ow = ow; m_oh = oh;
    if (changed) begin
      exp_q.push_back(model(nm, iw, ih, ow, oh));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    btn_pulse = 1'b0; hotplug = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(act === '0 && cfg_valid === 1'b0, "R1 reset", act, '0);

    // passthrough, smaller input: R7 border
    step(1280, 720, 1920, 1080, 0, 0, "R7 pass smaller");
    step(1280, 720, 1920, 1080, 1, 0, "R2 R9 up smaller");
    step(1280, 720, 1920, 1080, 1, 0, "R2 R10 R5 down smaller 852x480");
    step(1280, 720, 1920, 1080, 1, 0, "R2 pass again");
    // hot-plug with larger input goes to downscale
    step(3840, 2160, 1920, 1080, 0, 1, "R3 R11 hp larger");
    step(3840, 2160, 1920, 1080, 1, 0, "R6 pass larger");
    step(3840, 2160, 1920, 1080, 1, 0, "R8 R5 up larger 1280x720");
    step(1920, 1080, 1920, 1080, 0, 0, "R8 up equal");
    step(1920, 1080, 1920, 1080, 0, 1, "R3 R7 hp equal pass");
    step(1920, 1080, 1920, 1080, 1, 0, "R2 up equal");
    step(1920, 1080, 1920, 1080, 1, 0, "R11 down equal");
    // mixed: width over, height under counts as larger
    step(2000, 800, 1920, 1080, 0, 0, "R4 R11 down mixed");
    step(2000, 800, 1920, 1080, 1, 0, "R4 R6 pass mixed");
    // hot-plug wins over button in the same cycle
    step(1000, 600, 1920, 1080, 1, 1, "R3 hp priority");
    // hot-plug with nothing changed must stay silent
    p0 = pulses;
    step(1000, 600, 1920, 1080, 0, 1, "R3 silent");
    check(pulses == p0, "R3 silent hotplug", VW'(pulses), VW'(p0));
    step(1000, 600, 1920, 1080, 1, 0, "R9 up 1000x600");
    step(1000, 600, 1920, 1080, 1, 0, "R5 R10 down 664x400");
    repeat (6) @(negedge clk);
    // R12 outputs hold between strobes
    check(act === last_exp && cfg_valid === 1'b0, "R12 hold", act, last_exp);
    check(exp_q.size() == 0, "R12 missing strobe", VW'(exp_q.size()), '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule